// File: doc/BRIEF.md
# Dual-Processor Memory Mapper with Control Ports

This block sits on the bus of an 8-bit main processor and turns each memory cycle into chip selects for a boot ROM, a BASIC ROM, four option-slot ROMs, a RAM window shared with a second processor, and the main DRAM. It also produces the remapped upper address block for the DRAM. A two-bit memory state picks one of four address maps: boot, system, ROM BASIC and RAM BASIC. A four-bit bank field remaps the top 16 KB window. A three-bit field selects an option-slot ROM into the 2000h-3FFFh window.

Four I/O ports at FCh-FFh hold that state, together with the controls for the second processor. The main processor uses them to take that processor out of reset and to borrow its bus. Reads from the ports return the strap switches, the second processor's handshake lines and an encoded interrupt status. The block also inserts one wait clock on every opcode fetch. It generates RAS, CAS and the row/column multiplexer select for the DRAM, and it keeps CAS off during refresh.

Top module: `mm_mapper`

## Requirements
- R1: A port access is decoded only when iorq_ni is low, m1_ni is high and addr_i[7:2] are all ones. addr_i[1:0] pick the port: 0=FCh control, 1=FDh run/state, 2=FEh bank, 3=FFh status. Any other I/O address leaves every register unchanged.
- R2: While rst_ni is low, every register clears to zero. As a result sub_rst_no is 0 (second processor held in reset), sub_busreq_no is 1 (no bus request), the memory state is 0 and both bank fields are 0.
- R3: A write to FDh sets sub_rst_no to data bit 7, so writing 80h releases the second processor. The same write loads the memory state from data bits 1:0.
- R4: A write to FCh stores the whole byte. sub_busreq_no is the inverse of stored bit 1, so writing 02h asserts the bus request (low).
- R5: A write to FEh loads the upper-window bank from bits 3:0 and the slot field from bits 6:4. For addresses C000h-FFFFh in states 1-3, phys_blk_o = 3 + bank. In all other cases phys_blk_o = addr_i[15:14].
- R6: With mreq_ni low and rfsh_ni high, addresses F800h-FFFFh assert cs_shr_o in every state, and no other select is active.
- R7: In state 0, 0000h-1FFFh asserts cs_ipl_o and 4000h-5FFFh asserts ras_o. Every other address below F800h selects nothing. cs_ipl_o is never active outside state 0.
- R8: In states 2 and 3, 2000h-3FFFh asserts cs_slot_o[s-1] when the slot field s is 1-4. In state 2, other addresses below 8000h assert cs_basic_o. Every remaining address below F800h asserts ras_o, as does every address below F800h in state 1.
- R9: wait_oe_o is high for exactly the first clock of a memory cycle with m1_ni and mreq_ni both low, and low at all other times.
- R10: row_sel_o is high in the first clock of a DRAM access and low from the second clock on. cas_o follows from the second clock. A refresh cycle (mreq_ni and rfsh_ni both low) asserts ras_o and no chip select, and never asserts cas_o.
- R11: Reads return the following. FCh returns the stored byte. FDh returns {run, 5'b0, state}. FEh returns strap_i. FFh returns {sub_ready_i, sub_ack_i, 3'b0, code}, where code is 0 when no irq_i bit is set, otherwise the index of the lowest set bit plus 1.
- R12: data_oe_o is high only during a decoded port access with rd_ni low. Reads never change register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Main processor address |
| iorq_ni | input | 1 | I/O request, active low |
| mreq_ni | input | 1 | Memory request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| m1_ni | input | 1 | Opcode fetch / interrupt acknowledge, active low |
| rfsh_ni | input | 1 | Refresh cycle, active low |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Port read data |
| data_oe_o | output | 1 | Drive enable for data_o |
| strap_i | input | 8 | Strap switch inputs |
| sub_ready_i | input | 1 | Second processor ready |
| sub_ack_i | input | 1 | Second processor bus acknowledge |
| irq_i | input | 5 | Interrupt request lines, active high |
| cs_ipl_o | output | 1 | Boot ROM select |
| cs_basic_o | output | 1 | BASIC ROM select |
| cs_slot_o | output | 4 | Option-slot ROM selects |
| cs_shr_o | output | 1 | Shared RAM select |
| ras_o | output | 1 | DRAM row strobe |
| cas_o | output | 1 | DRAM column strobe |
| row_sel_o | output | 1 | DRAM address mux: 1 row, 0 column |
| phys_blk_o | output | 5 | Physical 16 KB block of the access |
| wait_oe_o | output | 1 | Drive wait (low) onto the bus |
| sub_rst_no | output | 1 | Second processor reset, active low |
| sub_busreq_no | output | 1 | Bus request to second processor, active low |

## Verification
The bench sweeps every memory state, every slot field value and 32 address regions. This targets the overlaps between the maps: the shared window inside the banked window, the slot window inside the BASIC ROM range, and the narrow DRAM range in state 0. A wrong priority there shows up as two selects at once, or as DRAM answering where a ROM should. All sixteen bank values are checked at the top window, and in state 0 as well, to catch a remap that is off by one or that leaks into the boot map. All 32 interrupt patterns are checked against the lowest-index-wins encoding. The wait and strobe tests hold a cycle for several clocks, which catches a wait that repeats or a CAS that fires during refresh. Near-miss port addresses and reads without IORQ are used to show that the registers stay unchanged.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    MS_BOOT = 2'd0,
    MS_SYS  = 2'd1,
    MS_ROMB = 2'd2,
    MS_RAMB = 2'd3
  } mstate_e;

  localparam logic [1:0] PORT_CTL  = 2'd0;
  localparam logic [1:0] PORT_RUN  = 2'd1;
  localparam logic [1:0] PORT_BANK = 2'd2;
  localparam logic [1:0] PORT_STAT = 2'd3;

  localparam logic [15:0] SHR_BASE = 16'hF800;
  localparam logic [15:0] ROMB_END = 16'h8000;
endpackage

// File: rtl/mm_regs.sv
module mm_regs #(
  parameter int BANK_W  = 4,
  parameter int WIN_W   = 3,
  parameter int N_IRQ   = 5,
  parameter int STRAP_W = 8,
  localparam int CODE_W = $clog2(N_IRQ + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               io_wr_i,
  input  logic               io_rd_i,
  input  logic [1:0]         sel_i,
  input  logic [7:0]         wdata_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               sub_ready_i,
  input  logic               sub_ack_i,
  input  logic [N_IRQ-1:0]   irq_i,
  output mm_pkg::mstate_e    ms_o,
  output logic [BANK_W-1:0]  ma_o,
  output logic [WIN_W-1:0]   mo_o,
  output logic               run_o,
  output logic               busreq_o,
  output logic [7:0]         rdata_o
);
  import mm_pkg::*;

  logic [7:0]        ctl_q;
  logic              run_q;
  mstate_e           ms_q;
  logic [BANK_W-1:0] ma_q;
  logic [WIN_W-1:0]  mo_q;
  logic [CODE_W-1:0] code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      run_q <= 1'b0;
      ms_q  <= MS_BOOT;
      ma_q  <= '0;
      mo_q  <= '0;
    end else if (io_wr_i) begin
      unique case (sel_i)
        PORT_CTL:  ctl_q <= wdata_i;
        PORT_RUN: begin
          run_q <= wdata_i[7];
          ms_q  <= mstate_e'(wdata_i[1:0]);
        end
        PORT_BANK: begin
          ma_q <= wdata_i[BANK_W-1:0];
          mo_q <= wdata_i[BANK_W +: WIN_W];
        end
        default: ;
      endcase
    end
  end

  // lowest index wins
  always_comb begin
    code = '0;
    for (int i = N_IRQ - 1; i >= 0; i--)
      if (irq_i[i]) code = CODE_W'(i + 1);
  end

  always_comb begin
    unique case (sel_i)
      PORT_CTL:  rdata_o = ctl_q;
      PORT_RUN:  rdata_o = {run_q, 5'b0, ms_q};
      PORT_BANK: rdata_o = 8'(strap_i);
      default:   rdata_o = {sub_ready_i, sub_ack_i, (6 - CODE_W)'(0), code};
    endcase
  end

  assign ms_o     = ms_q;
  assign ma_o     = ma_q;
  assign mo_o     = mo_q;
  assign run_o    = run_q;
  assign busreq_o = ctl_q[1];

  p_read_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !io_wr_i) |=> $stable({ctl_q, run_q, ms_q, ma_q, mo_q}));
endmodule

// File: rtl/mm_decode.sv
module mm_decode #(
  parameter int BANK_W = 4,
  parameter int WIN_W  = 3,
  parameter int N_SLOT = 4,
  localparam int BLK_W = BANK_W + 1
) (
  input  mm_pkg::mstate_e   ms_i,
  input  logic [BANK_W-1:0] ma_i,
  input  logic [WIN_W-1:0]  mo_i,
  input  logic [15:0]       addr_i,
  input  logic              mreq_i,
  input  logic              rfsh_i,
  output logic              cs_ipl_o,
  output logic              cs_basic_o,
  output logic [N_SLOT-1:0] cs_slot_o,
  output logic              cs_shr_o,
  output logic              dram_o,
  output logic [BLK_W-1:0]  phys_blk_o
);
  import mm_pkg::*;

  logic [2:0] hi;
  logic       acc, shr_hit, rom_state, slot_win, slot_any;

  assign hi        = addr_i[15:13];
  assign acc       = mreq_i && !rfsh_i;
  assign shr_hit   = addr_i >= SHR_BASE;
  assign rom_state = (ms_i == MS_ROMB) || (ms_i == MS_RAMB);
  assign slot_win  = acc && !shr_hit && rom_state && (hi == 3'd1);

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    assign cs_slot_o[s] = slot_win && (mo_i == WIN_W'(s + 1));
  end
  assign slot_any = |cs_slot_o;

  always_comb begin
    cs_ipl_o   = 1'b0;
    cs_basic_o = 1'b0;
    cs_shr_o   = 1'b0;
    dram_o     = mreq_i && rfsh_i;
    if (acc) begin
      if (shr_hit) cs_shr_o = 1'b1;
      else begin
        unique case (ms_i)
          MS_BOOT: begin
            cs_ipl_o = (hi == 3'd0);
            dram_o   = (hi == 3'd2);
          end
          MS_SYS:  dram_o = 1'b1;
          MS_ROMB: begin
            cs_basic_o = !slot_any && (addr_i < ROMB_END);
            dram_o     = !slot_any && (addr_i >= ROMB_END);
          end
          default: dram_o = !slot_any;
        endcase
      end
    end
  end

  always_comb begin
    if (ms_i != MS_BOOT && addr_i[15:14] == 2'b11)
      phys_blk_o = BLK_W'(ma_i) + BLK_W'(3);
    else
      phys_blk_o = BLK_W'(addr_i[15:14]);
  end
endmodule

// File: rtl/mm_timing.sv
module mm_timing (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fetch_i,
  input  logic dram_i,
  input  logic rfsh_i,
  output logic wait_oe_o,
  output logic row_sel_o,
  output logic cas_o
);
  logic fetch_q, dram_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= 1'b0;
      dram_q  <= 1'b0;
    end else begin
      fetch_q <= fetch_i;
      dram_q  <= dram_i;
    end
  end

  assign wait_oe_o = fetch_i && !fetch_q;
  assign row_sel_o = !(dram_i && dram_q);
  assign cas_o     = dram_i && dram_q && !rfsh_i;

  p_wait_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_oe_o |=> !wait_oe_o);
  p_cas_needs_ras_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_o |-> dram_i && $past(dram_i));
  p_no_cas_refresh_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_i |-> !cas_o);
endmodule

// File: rtl/mm_mapper.sv
module mm_mapper #(
  parameter int BANK_W  = 4,
  parameter int WIN_W   = 3,
  parameter int N_SLOT  = 4,
  parameter int N_IRQ   = 5,
  parameter int STRAP_W = 8,
  localparam int BLK_W  = BANK_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [15:0]        addr_i,
  input  logic               iorq_ni,
  input  logic               mreq_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic               m1_ni,
  input  logic               rfsh_ni,
  input  logic [7:0]         data_i,
  output logic [7:0]         data_o,
  output logic               data_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               sub_ready_i,
  input  logic               sub_ack_i,
  input  logic [N_IRQ-1:0]   irq_i,
  output logic               cs_ipl_o,
  output logic               cs_basic_o,
  output logic [N_SLOT-1:0]  cs_slot_o,
  output logic               cs_shr_o,
  output logic               ras_o,
  output logic               cas_o,
  output logic               row_sel_o,
  output logic [BLK_W-1:0]   phys_blk_o,
  output logic               wait_oe_o,
  output logic               sub_rst_no,
  output logic               sub_busreq_no
);
  import mm_pkg::*;

  logic              io_sel, io_wr, io_rd, run, busreq, dram;
  mstate_e           ms;
  logic [BANK_W-1:0] ma;
  logic [WIN_W-1:0]  mo;

  assign io_sel = !iorq_ni && m1_ni && (&addr_i[7:2]);
  assign io_wr  = io_sel && !wr_ni;
  assign io_rd  = io_sel && !rd_ni;

  mm_regs #(.BANK_W(BANK_W), .WIN_W(WIN_W), .N_IRQ(N_IRQ), .STRAP_W(STRAP_W)) u_regs (
    .clk_i, .rst_ni, .io_wr_i(io_wr), .io_rd_i(io_rd), .sel_i(addr_i[1:0]),
    .wdata_i(data_i), .strap_i, .sub_ready_i, .sub_ack_i, .irq_i,
    .ms_o(ms), .ma_o(ma), .mo_o(mo), .run_o(run), .busreq_o(busreq), .rdata_o(data_o)
  );

  mm_decode #(.BANK_W(BANK_W), .WIN_W(WIN_W), .N_SLOT(N_SLOT)) u_dec (
    .ms_i(ms), .ma_i(ma), .mo_i(mo), .addr_i, .mreq_i(!mreq_ni), .rfsh_i(!rfsh_ni),
    .cs_ipl_o, .cs_basic_o, .cs_slot_o, .cs_shr_o, .dram_o(dram), .phys_blk_o
  );

  mm_timing u_tim (
    .clk_i, .rst_ni, .fetch_i(!m1_ni && !mreq_ni), .dram_i(dram), .rfsh_i(!rfsh_ni),
    .wait_oe_o, .row_sel_o, .cas_o
  );

  assign ras_o         = dram;
  assign data_oe_o     = io_rd;
  assign sub_rst_no    = run;
  assign sub_busreq_no = !busreq;

  p_ipl_boot_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ipl_o |-> ms == MS_BOOT);
  p_one_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cs_ipl_o, cs_basic_o, cs_slot_o, cs_shr_o, ras_o}));
  p_oe_needs_rd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !iorq_ni && !rd_ni);
endmodule

// File: tb/mm_mapper_tb_top.sv
module mm_mapper_tb_top;
  logic        clk = 0, rst_ni = 0;
  logic [15:0] addr = 0;
  logic iorq_n = 1, mreq_n = 1, rd_n = 1, wr_n = 1, m1_n = 1, rfsh_n = 1;
  logic [7:0]  din = 0, dout, strap = 8'h5A;
  logic        doe, rdy = 1, ack = 0;
  logic [4:0]  irq = 0;
  logic cs_ipl, cs_basic, cs_shr, ras, cas, row_sel, wait_oe, srst_n, sbreq_n;
  logic [3:0]  cs_slot;
  logic [4:0]  phys;
  int nvec = 0, nfail = 0;

  always #2.5 clk = ~clk;

  mm_mapper dut_i (
    .clk_i(clk), .rst_ni, .addr_i(addr), .iorq_ni(iorq_n), .mreq_ni(mreq_n),
    .rd_ni(rd_n), .wr_ni(wr_n), .m1_ni(m1_n), .rfsh_ni(rfsh_n), .data_i(din),
    .data_o(dout), .data_oe_o(doe), .strap_i(strap), .sub_ready_i(rdy),
    .sub_ack_i(ack), .irq_i(irq), .cs_ipl_o(cs_ipl), .cs_basic_o(cs_basic),
    .cs_slot_o(cs_slot), .cs_shr_o(cs_shr), .ras_o(ras), .cas_o(cas),
    .row_sel_o(row_sel), .phys_blk_o(phys), .wait_oe_o(wait_oe),
    .sub_rst_no(srst_n), .sub_busreq_no(sbreq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    iorq_n = 1; mreq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1; rfsh_n = 1;
  endtask

  task automatic io_wr(input logic [7:0] port, input logic [7:0] d);
    @(negedge clk);
    addr = {8'h12, port}; din = d; iorq_n = 0; wr_n = 0;
    idle();
  endtask

  task automatic io_rd(input logic [7:0] port, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = {8'h34, port}; iorq_n = 0; rd_n = 0;
    #1;
    chk(req, {doe, dout}, {1'b1, exp});
    idle();
  endtask

  function automatic logic [12:0] exp_dec(input logic [1:0] ms, input logic [2:0] mo,
                                          input logic [3:0] ma, input logic [15:0] a);
    logic ipl = 0, bas = 0, shr = 0, r = 0;
    logic [3:0] sl = 0;
    logic [4:0] pb;
    if (a >= 16'hF800) shr = 1;
    else if (ms == 0) begin
      ipl = a < 16'h2000;
      r = a >= 16'h4000 && a < 16'h6000;
    end else if (ms == 1) r = 1;
    else if (a >= 16'h2000 && a < 16'h4000 && mo >= 1 && mo <= 4) sl[mo-1] = 1;
    else if (ms == 2 && a < 16'h8000) bas = 1;
    else r = 1;
    pb = (ms != 0 && a >= 16'hC000) ? 5'(ma) + 5'd3 : 5'(a[15:14]);
    return {ipl, bas, sl, shr, r, pb};
  endfunction

  task automatic mem_chk(input logic [1:0] ms, input logic [2:0] mo, input logic [3:0] ma,
                         input logic [15:0] a, input string req);
    @(negedge clk);
    addr = a; mreq_n = 0; rd_n = 0;
    #1;
    chk(req, {cs_ipl, cs_basic, cs_slot, cs_shr, ras, phys}, exp_dec(ms, mo, ma, a));
    idle();
  endtask

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R2 reset state
    chk("R2 sub_rst_no", srst_n, 0);
    chk("R2 sub_busreq_no", sbreq_n, 1);
    rst_ni = 1;
    io_rd(8'hFD, 8'h00, "R2 run/state");
    io_rd(8'hFE, 8'h5A, "R11 strap");
    io_rd(8'hFC, 8'h00, "R2 ctl");

    // R1 near-miss ports leave state untouched
    io_wr(8'h7D, 8'h83);
    io_wr(8'hBD, 8'h83);
    io_wr(8'hF9, 8'h83);
    @(negedge clk); addr = 16'h00FD; din = 8'h83; iorq_n = 0; wr_n = 0; m1_n = 0; idle();
    #1 chk("R1 no release", srst_n, 0);
    io_rd(8'hFD, 8'h00, "R1 state unchanged");

    // R3 / R4
    io_wr(8'hFD, 8'h80);
    #1 chk("R3 released", srst_n, 1);
    io_wr(8'hFC, 8'h02);
    #1 chk("R4 busreq", sbreq_n, 0);
    io_rd(8'hFC, 8'h02, "R4 ctl readback");
    io_wr(8'hFC, 8'hFD);
    #1 chk("R4 busreq off", sbreq_n, 1);
    io_rd(8'hFC, 8'hFD, "R4 ctl full byte");
    io_wr(8'hFF, 8'h00);
    io_rd(8'hFD, 8'h80, "R1 FF write ignored");

    // R12 read without iorq or with wr-free rd only
    @(negedge clk); addr = 16'h00FD; rd_n = 0; #1;
    chk("R12 oe without iorq", doe, 0);
    idle();
    @(negedge clk); addr = 16'h00FD; iorq_n = 0; #1;
    chk("R12 oe without rd", doe, 0);
    idle();
    io_rd(8'hFD, 8'h80, "R12 state after reads");

    // R6 R7 R8 decode sweep
    for (int ms = 0; ms < 4; ms++) begin
      io_wr(8'hFD, {1'b1, 5'b0, 2'(ms)});
      for (int mo = 0; mo < 8; mo++) begin
        io_wr(8'hFE, {1'b0, 3'(mo), 4'hA});
        for (int k = 0; k < 32; k++)
          mem_chk(2'(ms), 3'(mo), 4'hA, {5'(k), 11'h3A5}, "R6/R7/R8 decode");
      end
      @(negedge clk); addr = 16'h0000; #1;
      chk("R7 idle no select", {cs_ipl, cs_basic, cs_slot, cs_shr, ras}, 0);
    end

    // R5 bank sweep, state 1 and state 0
    for (int b = 0; b < 16; b++) begin
      io_wr(8'hFD, 8'h81);
      io_wr(8'hFE, {4'h0, 4'(b)});
      mem_chk(2'd1, 3'd0, 4'(b), 16'hC123, "R5 bank remap");
      mem_chk(2'd1, 3'd0, 4'(b), 16'h8123, "R5 below window");
      io_wr(8'hFD, 8'h80);
      mem_chk(2'd0, 3'd0, 4'(b), 16'hC123, "R5 boot no remap");
    end

    // R11 interrupt code sweep
    for (int v = 0; v < 32; v++) begin
      int c = 0;
      for (int i = 4; i >= 0; i--) if (v[i]) c = i + 1;
      irq = 5'(v); rdy = v[0]; ack = v[1];
      io_rd(8'hFF, {rdy, ack, 3'b0, 3'(c)}, "R11 status");
    end

    // R9 wait on fetch
    for (int n = 1; n <= 3; n++) begin
      @(negedge clk); addr = 16'h4000; m1_n = 0; mreq_n = 0; #1;
      chk("R9 wait first clock", wait_oe, 1);
      repeat (n) begin @(negedge clk); #1; chk("R9 wait once", wait_oe, 0); end
      idle(); #1;
      chk("R9 idle", wait_oe, 0);
    end
    @(negedge clk); mreq_n = 0; #1; chk("R9 non-fetch no wait", wait_oe, 0); idle();

    // R10 strobes (state 0, 4000h is DRAM)
    @(negedge clk); addr = 16'h4000; mreq_n = 0; rd_n = 0; #1;
    chk("R10 first clock", {ras, row_sel, cas}, 3'b110);
    @(negedge clk); #1;
    chk("R10 second clock", {ras, row_sel, cas}, 3'b101);
    @(negedge clk); #1;
    chk("R10 third clock", {ras, row_sel, cas}, 3'b101);
    idle();
    @(negedge clk); addr = 16'h0100; mreq_n = 0; rfsh_n = 0; #1;
    chk("R10 refresh first", {cs_ipl, cs_shr, ras, cas}, 4'b0010);
    @(negedge clk); #1;
    chk("R10 refresh no cas", {cs_ipl, cs_shr, ras, cas}, 4'b0010);
    idle();
    @(negedge clk); addr = 16'hF900; mreq_n = 0; rfsh_n = 0; #1;
    chk("R10 refresh no shared cs", {cs_shr, ras, cas}, 3'b010);
    idle();

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule